// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product in a single combinational pass. It has no clock and no state, so the product follows the operands with only gate delay. Registers, if any, belong to the surrounding datapath.

The multiplier operand is read two bits at a time. A zero is appended below its least significant bit, so the triplets overlap. Each triplet is recoded into a digit in {-2, -1, 0, +1, +2}. Per-bit selectors turn that digit and the multiplicand into one partial-product row, which gives N/2 rows instead of N. A negative digit is formed by inverting the row; the +1 that completes the negation goes into a separate correction operand. Sign extension is not replicated across the upper columns. Instead, each row carries its inverted sign bit, and one precomputed constant of leading ones balances all rows at once. The neg increments share that correction operand.

The N/2+1 operands are reduced by a chain of carry-save rows to one sum/carry pair. A single carry-propagate adder then produces the product.

Top module: `booth_r4_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the signed product of `mcand_i` and `mplier_i`, taken over 2N bits (N even, N >= 4, default 8).
- R2: The multiplier is split into N/2 overlapping triplets; triplet i is {x[2i+1], x[2i], x[2i-1]}, with x[-1] = 0.
- R3: Triplet recoding (bit 2 first): 000 and 111 select 0; 001 and 010 select +Y; 011 selects +2Y; 100 selects -2Y; 101 and 110 select -Y. At most one of the magnitude selects (Y, 2Y) is active, and a zero digit is never marked negative.
- R4: A partial-product row is N+1 bits. Its value plus the row's negate bit equals the recoded digit times the multiplicand. The negate bit is added at column 2i, the weight of row i.
- R5: Each carry-save stage maps three 2N-bit operands to a sum and a carry (carry weighted twice, shifted one column left) with the same total modulo 2^(2N). K operands use K-2 such stages.
- R6: Row signs are handled by inverting each row's sign bit and adding one constant with ones in the upper columns. The extreme case holds: the most negative value times itself gives 2^(2N-2), and the most negative value times -1 gives 2^(N-1).
- R7: If either operand is zero, the product is zero.
- R8: If both operands are nonzero, the product's top bit equals the XOR of the operands' top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | N | Multiplicand Y, two's complement |
| mplier_i | input | N | Multiplier X, two's complement, scanned by triplets |
| prod_o | output | 2N | Signed product X*Y |

## Verification
The most negative operand is the hardest corner. Its digit pattern ends in -2 at the top group, and squaring it sets bit 2N-2 while leaving the sign bit clear. A design with a wrong sign-correction constant or a missing inverted sign bit gives a negative or off-by-2^N result there.

Multipliers of alternating patterns (0x55, 0xAA, 0x33, 0xCC and others) force every triplet code into every group. A swapped code or a dropped negate increment shows up as an error of one multiplicand at a weight of 4^i.

A full sweep over all operand pairs covers carries that ripple across the whole CSA chain. A mis-shifted carry vector there doubles or halves some of the terms.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Recoded digit controls for one group: magnitude 1, magnitude 2, negate.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bctl_t;

  // Recode one overlapping triplet {hi, mid, lo} into select controls.
  function automatic bctl_t booth_code(input logic [2:0] t);
    bctl_t c;
    c = '0;
    unique case (t)
      3'b001, 3'b010: c.one = 1'b1;
      3'b011:         c.two = 1'b1;
      3'b100: begin   c.two = 1'b1; c.neg = 1'b1; end
      3'b101, 3'b110: begin c.one = 1'b1; c.neg = 1'b1; end
      default:        c = '0;
    endcase
    return c;
  endfunction

  // Arithmetic weight of a triplet: -2*hi + mid + lo.
  function automatic int trip_weight(input logic [2:0] t);
    return int'(t[1]) + int'(t[0]) - 2 * int'(t[2]);
  endfunction

  // Signed digit implied by a set of controls.
  function automatic int ctl_weight(input bctl_t c);
    int w;
    w = c.two ? 2 : (c.one ? 1 : 0);
    return c.neg ? -w : w;
  endfunction

endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]          mplier_i,
  output bctl_t [(N/2)-1:0]     ctl_o
);
  localparam int M = N / 2;

  logic [N:0] xe;
  assign xe = {mplier_i, 1'b0};

  for (genvar g = 0; g < M; g++) begin : g_grp
    logic [2:0] trip;
    assign trip     = xe[2*g+2 -: 3];
    assign ctl_o[g] = booth_code(trip);

    always_comb begin
      p_sel_onehot_r3: assert ($onehot0({ctl_o[g].one, ctl_o[g].two}))
        else $error("R3 group %0d selects both magnitudes", g);
      p_zero_not_neg_r3: assert (!((trip == 3'b000 || trip == 3'b111) && ctl_o[g] != '0))
        else $error("R3 zero digit carries controls in group %0d", g);
      p_digit_r2: assert (ctl_weight(ctl_o[g]) == trip_weight(trip))
        else $error("R2 group %0d digit mismatch", g);
    end
  end
endmodule

// File: rtl/booth_sel.sv
module booth_sel
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] mcand_i,
  input  bctl_t        ctl_i,
  output logic [N:0]   row_o
);
  logic [N:0] y1, y2, mag;

  assign y1 = {mcand_i[N-1], mcand_i};
  assign y2 = {mcand_i, 1'b0};

  for (genvar b = 0; b <= N; b++) begin : g_bit
    assign mag[b]   = (ctl_i.one & y1[b]) | (ctl_i.two & y2[b]);
    assign row_o[b] = mag[b] ^ ctl_i.neg;
  end

  always_comb begin
    p_row_value_r4: assert ((int'($signed(row_o)) + int'(ctl_i.neg)) ==
                            ctl_weight(ctl_i) * int'($signed(mcand_i)))
      else $error("R4 row value disagrees with digit");
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] maj;

  for (genvar b = 0; b < W; b++) begin : g_fa
    assign sum_o[b] = a_i[b] ^ b_i[b] ^ d_i[b];
    assign maj[b]   = (a_i[b] & b_i[b]) | (a_i[b] & d_i[b]) | (b_i[b] & d_i[b]);
  end
  assign carry_o = {maj[W-2:0], 1'b0};

  logic [W-1:0] tot_in, tot_out;
  always_comb begin
    tot_in  = a_i + b_i + d_i;
    tot_out = sum_o + carry_o;
    p_csa_conserve_r5: assert (tot_in == tot_out)
      else $error("R5 carry-save stage lost value");
  end
endmodule

// File: rtl/csa_reduce.sv
module csa_reduce #(
  parameter int W = 16,
  parameter int K = 5
) (
  input  logic [K-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o,
  output logic [W-1:0]        carry_o
);
  if (K >= 3) begin : g_chain
    localparam int S = K - 2;
    logic [S:0][W-1:0] s, c;
    assign s[0] = ops_i[0];
    assign c[0] = ops_i[1];
    for (genvar j = 0; j < S; j++) begin : g_stage
      csa_row #(.W(W)) u_row (
        .a_i    (s[j]),
        .b_i    (c[j]),
        .d_i    (ops_i[j+2]),
        .sum_o  (s[j+1]),
        .carry_o(c[j+1])
      );
    end
    assign sum_o   = s[S];
    assign carry_o = c[S];
  end else begin : g_pass
    assign sum_o   = ops_i[0];
    assign carry_o = (K == 2) ? ops_i[K-1] : '0;
  end
endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] prod_o
);
  localparam int M = N / 2;
  localparam int W = 2 * N;
  localparam int K = M + 1;

  // Constant that balances every row's inverted sign bit: -sum(2^(N+2i)).
  function automatic logic [W-1:0] sign_const();
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < M; i++) acc = acc + (W'(1) << (N + 2*i));
    return -acc;
  endfunction
  localparam logic [W-1:0] SIGN_K = sign_const();

  bctl_t [M-1:0]       ctl;
  logic  [M-1:0][N:0]  rows;
  logic  [K-1:0][W-1:0] ops;
  logic  [W-1:0]       neg_row;
  logic  [W-1:0]       red_sum, red_carry;

  booth_enc #(.N(N)) u_enc (
    .mplier_i(mplier_i),
    .ctl_o   (ctl)
  );

  for (genvar g = 0; g < M; g++) begin : g_pp
    booth_sel #(.N(N)) u_sel (
      .mcand_i(mcand_i),
      .ctl_i  (ctl[g]),
      .row_o  (rows[g])
    );
    assign ops[g] = {{(W-N-1){1'b0}}, ~rows[g][N], rows[g][N-1:0]} << (2*g);
  end

  always_comb begin
    neg_row = '0;
    for (int g = 0; g < M; g++) neg_row[2*g] = ctl[g].neg;
  end
  assign ops[M] = SIGN_K | neg_row;

  csa_reduce #(.W(W), .K(K)) u_red (
    .ops_i  (ops),
    .sum_o  (red_sum),
    .carry_o(red_carry)
  );

  assign prod_o = red_sum + red_carry;

  always_comb begin
    p_zero_r7: assert (!((mcand_i == '0 || mplier_i == '0) && prod_o != '0))
      else $error("R7 zero operand gave nonzero product");
    p_sign_r8: assert (!(mcand_i != '0 && mplier_i != '0 &&
                         prod_o[W-1] != (mcand_i[N-1] ^ mplier_i[N-1])))
      else $error("R8 product sign wrong");
    p_corr_disjoint_r6: assert ((neg_row & SIGN_K) == '0)
      else $error("R6 correction bits collide");
  end
endmodule

// File: tb/tb_booth_r4_mult.sv
module tb_booth_r4_mult;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0] a, b;
  logic [W-1:0] p;
  int n_chk = 0;
  int n_bad = 0;

  booth_r4_mult #(.N(N)) dut (.mcand_i(a), .mplier_i(b), .prod_o(p));

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] y, input logic [N-1:0] x);
    longint sy, sx;
    sy = longint'($signed(y));
    sx = longint'($signed(x));
    return W'(sy * sx);
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%0h b=%0h got %0h expected %0h", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] y, input logic [N-1:0] x);
    @(posedge clk);
    a = y;
    b = x;
    @(negedge clk);
  endtask

  task automatic t_idle();
    apply('0, '0);
    check("R7 idle", p, '0);
    apply(8'h5B, '0);
    check("R7 zero mplier", p, '0);
    apply('0, 8'h80);
    check("R7 zero mcand", p, '0);
  endtask

  task automatic t_corner();
    apply(8'h80, 8'h80);
    check("R6 min*min", p, 16'h4000);
    apply(8'h80, 8'hFF);
    check("R6 min*-1", p, 16'h0080);
    apply(8'h7F, 8'h7F);
    check("R1 max*max", p, 16'h3F01);
    apply(8'hFF, 8'hFF);
    check("R1 -1*-1", p, 16'h0001);
    apply(8'h80, 8'h7F);
    check("R6 min*max", p, 16'hC080);
    apply(8'h01, 8'h80);
    check("R6 1*min", p, 16'hFF80);
  endtask

  task automatic t_triplet();
    logic [N-1:0] pats [8] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h66, 8'h99, 8'h01, 8'h80};
    logic [N-1:0] ys   [3] = '{8'h5B, 8'hC9, 8'h80};
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 3; j++) begin
        apply(ys[j], pats[i]);
        check("R3 R4 R2 triplet codes", p, ref_mul(ys[j], pats[i]));
      end
    end
  endtask

  task automatic t_sign();
    logic [N-1:0] v [4] = '{8'h03, 8'hFD, 8'h40, 8'hC0};
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        apply(v[i], v[j]);
        check("R8 sign", {15'b0, p[W-1]}, {15'b0, v[i][N-1] ^ v[j][N-1]});
      end
    end
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[15:8], lfsr[7:0]);
      check("R5 random carry-save", p, ref_mul(lfsr[15:8], lfsr[7:0]));
    end
  endtask

  task automatic t_sweep();
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        apply(N'(i), N'(j));
        check("R1 sweep", p, ref_mul(N'(i), N'(j)));
      end
    end
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset state", p, '0);
    t_idle();
    t_corner();
    t_triplet();
    t_sign();
    t_random();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule